// File: doc/BRIEF.md
# GPIO Pin Function and Output Register File

This block is the control register file for a port of general-purpose pins (54 by default). Each pin has a 3-bit function code that makes it an input, a driven output, or one of six alternate functions routed by a pad multiplexer. The function codes sit in 3-bit fields packed ten to a 32-bit register. A separate per-pin output latch holds the value to drive. Software never writes that latch directly. It writes ones to a set register to raise bits and ones to a clear register to lower them, so it never has to read, modify and write the latch.

The bus is a plain single-cycle interface. A write is accepted on the rising clock edge while `bus_wr` is high. Read data is a combinational function of `bus_addr`. A read-only level register returns the live pin inputs in banks of 32. For each pin the block drives an output value, an output enable, an alternate-function enable and a 3-bit alternate-function index. The pad multiplexer uses these.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every pin is an input (function code 000) and every output latch is 0. All function-select registers read 0, and `pin_oe`, `pin_out` and `pin_alt_en` are all 0.
- R2: Function codes decode as follows: 000 input, 001 output (`pin_oe`=1), 100/101/110/111 alternate 0/1/2/3, 011 alternate 4, 010 alternate 5. For an alternate code, `pin_alt_en`=1 and `pin_alt_sel` carries the alternate number. Otherwise `pin_alt_en`=0 and `pin_alt_sel`=0.
- R3: The function field of pin n lives in the register at byte offset 4*(n/10), at bits 3*(n%10)+2 down to 3*(n%10). Writing that register sets the field, and reading it returns the field.
- R4: A write to the set register of bank b (byte offset 0x1C+4*b) sets the latch of pin 32*b+i for every data bit i that is 1. Bits that are 0 leave their latches unchanged.
- R5: A write to the clear register of bank b (byte offset 0x28+4*b) clears the latch of pin 32*b+i for every data bit i that is 1. Bits that are 0 leave their latches unchanged.
- R6: Reading byte offset 0x34+4*b returns `pin_in` of pins 32*b to 32*b+31 at bits 0 to 31. Bits for pins beyond the last pin read 0.
- R7: `pin_out` equals the pin's latch while its code is 001, and is 0 otherwise. The latch keeps its value across function changes, so a value set while the pin is an input appears once the pin becomes an output.
- R8: The set and clear registers read 0. Every address not listed in R3, R4, R5 and R6 reads 0.
- R9: Bits 30 and 31 of every function-select register, and the fields of pins beyond the last pin, ignore writes and read 0.
- R10: A write changes the outputs and the read data from the first clock edge that accepts it. The new values are visible in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, accepted on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS (54) | Live pin input levels |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_alt_en | output | NUM_PINS | Pin is in an alternate function |
| pin_alt_sel | output | 3*NUM_PINS | Alternate-function index, 3 bits per pin |

## Verification
Register writes take effect at the rising edge that accepts them. The pin outputs and the read data carry the new values by the following falling edge. The reference model applies each write just after that edge, and every falling edge compares all pin outputs against it. Read data has no register on its path, so each read check drives the address at a falling edge and samples two time units later. For the level register, the read depends only on `pin_in` at that moment.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int DATA_W        = 32;
  localparam int FLD_W         = 3;
  localparam int PINS_PER_SEL  = 10;
  localparam int PINS_PER_BANK = 32;
  localparam int SEL_DATA_W    = FLD_W * PINS_PER_SEL;

  // word indices (byte offset / 4) of the register groups
  localparam int WORD_SEL0 = 0;
  localparam int WORD_SET0 = 7;
  localparam int WORD_CLR0 = 10;
  localparam int WORD_LEV0 = 13;

  typedef enum logic [FLD_W-1:0] {
    FN_IN   = 3'b000,
    FN_OUT  = 3'b001,
    FN_ALT5 = 3'b010,
    FN_ALT4 = 3'b011,
    FN_ALT0 = 3'b100,
    FN_ALT1 = 3'b101,
    FN_ALT2 = 3'b110,
    FN_ALT3 = 3'b111
  } pin_fn_e;

  function automatic int sel_word_of(int pin);
    return WORD_SEL0 + pin / PINS_PER_SEL;
  endfunction

  function automatic int sel_lsb_of(int pin);
    return FLD_W * (pin % PINS_PER_SEL);
  endfunction

  function automatic int bank_of(int pin);
    return pin / PINS_PER_BANK;
  endfunction

  function automatic int bank_bit_of(int pin);
    return pin % PINS_PER_BANK;
  endfunction

  function automatic logic fn_is_alt(logic [FLD_W-1:0] code);
    return code[2] | code[1];
  endfunction

  // 1xx -> alt0..3 from the low bits, 011 -> alt4, 010 -> alt5
  function automatic logic [FLD_W-1:0] fn_alt_index(logic [FLD_W-1:0] code);
    if (code[2])      return {1'b0, code[1:0]};
    else if (code[1]) return code[0] ? 3'd4 : 3'd5;
    else              return 3'd0;
  endfunction

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8,
  localparam int NUM_SEL = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [NUM_SEL-1:0]  sel_we,
  output logic [NUM_PINS-1:0] set_mask,
  output logic [NUM_PINS-1:0] clr_mask
);
  logic [ADDR_W-1:0] word_idx;
  assign word_idx = bus_addr >> 2;

  for (genvar r = 0; r < NUM_SEL; r++) begin : g_sel_we
    assign sel_we[r] = bus_wr && (int'(word_idx) == WORD_SEL0 + r);
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_mask
    localparam int BANK = bank_of(n);
    localparam int BIT  = bank_bit_of(n);
    assign set_mask[n] = bus_wr && (int'(word_idx) == WORD_SET0 + BANK) && bus_wdata[BIT];
    assign clr_mask[n] = bus_wr && (int'(word_idx) == WORD_CLR0 + BANK) && bus_wdata[BIT];
  end
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 54,
  localparam int NUM_SEL = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SEL-1:0]        sel_we,
  input  logic [SEL_DATA_W-1:0]     sel_wdata,
  output logic [FLD_W*NUM_PINS-1:0] fn_flat
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int WORD = sel_word_of(n) - WORD_SEL0;
    localparam int LSB  = sel_lsb_of(n);
    logic [FLD_W-1:0] fn_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            fn_q <= FN_IN;
      else if (sel_we[WORD]) fn_q <= sel_wdata[LSB +: FLD_W];
    end
    assign fn_flat[n*FLD_W +: FLD_W] = fn_q;
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_mask,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] latch_q
);
  // clear wins over set on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_PINS-1:0]       pin_in,
  output logic [NUM_PINS-1:0]       pin_out,
  output logic [NUM_PINS-1:0]       pin_oe,
  output logic [NUM_PINS-1:0]       pin_alt_en,
  output logic [FLD_W*NUM_PINS-1:0] pin_alt_sel
);
  localparam int NUM_SEL = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;

  logic [NUM_SEL-1:0]        sel_we;
  logic [NUM_PINS-1:0]       set_mask;
  logic [NUM_PINS-1:0]       clr_mask;
  logic [NUM_PINS-1:0]       latch_q;
  logic [FLD_W*NUM_PINS-1:0] fn_flat;

  gpio_wr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sel_we   (sel_we),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  gpio_fsel_regs #(.NUM_PINS(NUM_PINS)) u_fsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (sel_we),
    .sel_wdata(bus_wdata[SEL_DATA_W-1:0]),
    .fn_flat  (fn_flat)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_mask(set_mask),
    .clr_mask(clr_mask),
    .latch_q (latch_q)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
    logic [FLD_W-1:0] code;
    assign code                           = fn_flat[n*FLD_W +: FLD_W];
    assign pin_oe[n]                      = (code == FN_OUT);
    assign pin_out[n]                     = latch_q[n] & pin_oe[n];
    assign pin_alt_en[n]                  = fn_is_alt(code);
    assign pin_alt_sel[n*FLD_W +: FLD_W]  = fn_alt_index(code);
  end

  logic [ADDR_W-1:0] rd_word;
  assign rd_word = bus_addr >> 2;

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (int'(rd_word) == sel_word_of(n))
        bus_rdata[sel_lsb_of(n) +: FLD_W] = fn_flat[n*FLD_W +: FLD_W];
      if (int'(rd_word) == WORD_LEV0 + bank_of(n))
        bus_rdata[bank_bit_of(n)] = pin_in[n];
    end
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] set_mask,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic [NUM_PINS-1:0] latch_q,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_alt_en
);
  logic [ADDR_W-1:0] word_idx;
  logic              strobe_word;
  assign word_idx    = bus_addr >> 2;
  assign strobe_word = (int'(word_idx) == WORD_SET0) || (int'(word_idx) == WORD_SET0 + 1) ||
                       (int'(word_idx) == WORD_CLR0) || (int'(word_idx) == WORD_CLR0 + 1);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && pin_alt_en == '0 && latch_q == '0)); // R1

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_alt_en) == '0); // R2

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask && clr_mask == '0) |=> ((latch_q & $past(set_mask)) == $past(set_mask))); // R4

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((latch_q & $past(clr_mask)) == '0)); // R5

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(latch_q)); // R4

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R7

  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_word |-> bus_rdata == '0); // R8
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .set_mask  (set_mask),
  .clr_mask  (clr_mask),
  .latch_q   (latch_q),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_alt_en(pin_alt_en)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_alt_en;
  logic [3*NP-1:0] pin_alt_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int fn_m [NP];
  bit lat_m [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt_en(pin_alt_en),
    .pin_alt_sel(pin_alt_sel)
  );

  task automatic check(string tag, logic [191:0] act, logic [191:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int alt_num(int code);
    case (code)
      4: return 0;
      5: return 1;
      6: return 2;
      7: return 3;
      3: return 4;
      2: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int addr);
    logic [31:0] v = '0;
    int w = addr / 4;
    if (w <= 5) begin
      for (int k = 0; k < 10; k++)
        if (w * 10 + k < NP) v[3*k +: 3] = 3'(fn_m[w*10+k]);
    end else if (w == 13 || w == 14) begin
      for (int k = 0; k < 32; k++)
        if ((w - 13) * 32 + k < NP) v[k] = pin_in[(w-13)*32+k];
    end
    return v;
  endfunction

  // R2 R7 R10: all pin outputs compared against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NP-1:0] e_oe, e_out, e_alt;
      logic [3*NP-1:0] e_sel;
      e_oe = '0; e_out = '0; e_alt = '0; e_sel = '0;
      for (int n = 0; n < NP; n++) begin
        e_oe[n]  = (fn_m[n] == 1);
        e_out[n] = lat_m[n] && (fn_m[n] == 1);
        e_alt[n] = (alt_num(fn_m[n]) >= 0);
        if (e_alt[n]) e_sel[3*n +: 3] = 3'(alt_num(fn_m[n]));
      end
      check("R2 pin_oe", 192'(pin_oe), 192'(e_oe));
      check("R2 pin_alt_en", 192'(pin_alt_en), 192'(e_alt));
      check("R2 pin_alt_sel", 192'(pin_alt_sel), 192'(e_sel));
      check("R7 pin_out", 192'(pin_out), 192'(e_out));
    end
  end

  task automatic wr(int addr, logic [31:0] data);
    int w;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(posedge clk);
    #1;
    w = addr / 4;
    if (w <= 5) begin
      for (int k = 0; k < 10; k++)
        if (w * 10 + k < NP) fn_m[w*10+k] = int'(data[3*k +: 3]);
    end else if (w == 7 || w == 8 || w == 10 || w == 11) begin
      for (int k = 0; k < 32; k++) begin
        int p = ((w == 8 || w == 11) ? 32 : 0) + k;
        if (p < NP && data[k]) lat_m[p] = (w == 7 || w == 8);
      end
    end
    bus_wr = 1'b0;
  endtask

  task automatic rd(int addr, string tag);
    @(negedge clk);
    bus_addr = AW'(addr);
    #2;
    check(tag, 192'(bus_rdata), 192'(exp_read(addr)));
  endtask

  initial begin
    logic [31:0] lfsr;
    int addrs [10] = '{0, 4, 8, 12, 16, 20, 28, 32, 40, 44};
    for (int n = 0; n < NP; n++) begin fn_m[n] = 0; lat_m[n] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state of the select registers
    for (int r = 0; r < 6; r++) rd(4*r, "R1 fsel reset read");

    // R3 R9 all codes across register 0, top two bits written high
    wr('h00, 32'hC000_0000 | (32'(1) << 27) | (32'(2) << 18) | (32'(3) << 15) |
             (32'(7) << 12) | (32'(6) << 9) | (32'(5) << 6) | (32'(4) << 3) | 32'(1));
    rd('h00, "R3 R9 fsel0 readback");
    check("R9 bits30-31 zero", 192'(bus_rdata[31:30]), 192'(0));

    // R4 set all of bank 0
    wr('h1C, 32'hFFFF_FFFF);
    check("R4 pin0 high", 192'(pin_out[0]), 192'(1));
    // R5 clear pin 0 only
    wr('h28, 32'h0000_0001);
    #3 check("R5 pin0 low", 192'(pin_out[0]), 192'(0));
    check("R5 pin9 kept", 192'(pin_out[9]), 192'(1));
    // R4 R5 zero data changes nothing
    wr('h1C, 32'h0); wr('h28, 32'h0);
    #3 check("R4 zero set no effect", 192'(pin_out[9]), 192'(1));

    // R7 latch set while input shows once output
    wr('h2C, 32'hFFFF_FFFF);
    wr('h20, 32'h0000_0010);      // pin 36 latch high while input
    #3 check("R7 input pin low", 192'(pin_out[36]), 192'(0));
    wr('h0C, 32'(1) << 18);        // pin 36 -> output
    #3 check("R7 retained value", 192'(pin_out[36]), 192'(1));

    // R9 fields beyond last pin
    wr('h14, 32'hFFFF_FFFF);
    rd('h14, "R9 fsel5 readback");
    check("R9 fsel5 value", 192'(bus_rdata), 192'(32'h0000_0FFF));

    // R8 strobe registers and holes read zero
    rd('h1C, "R8 set read"); rd('h20, "R8 set1 read");
    rd('h28, "R8 clr read"); rd('h2C, "R8 clr1 read");
    rd('h18, "R8 hole 18"); rd('h30, "R8 hole 30"); rd('h3C, "R8 hole 3C");
    check("R8 hole value", 192'(bus_rdata), 192'(0));

    // R6 level register
    pin_in = 54'h2A_5A5A_F0F0_1234;
    rd('h34, "R6 level bank0");
    rd('h38, "R6 level bank1");
    pin_in = '1;
    rd('h38, "R6 level bank1 ones");
    check("R6 upper bits zero", 192'(bus_rdata), 192'(32'h003F_FFFF));

    // R2 R3 R4 R5 R10 pseudo-random register traffic
    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(addrs[lfsr[3:0] % 10], lfsr ^ 32'h9E37_79B9);
      if (i % 8 == 0) rd(addrs[lfsr[7:4] % 6], "R3 random readback");
    end

    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule